// File: doc/BRIEF.md
# YCbCr 4:2:2 Output Port Formatter

This block sits between an internal sample-rate converter and the external video data port. The converter hands over one 4:2:2 sample at a time, in bursts, with a valid pulse: an 8-bit luma value, an 8-bit chroma value and a flag that says whether the sample lies in the visible part of the line. Upstream delivers chroma in pairs, blue-difference first and red-difference second.

Two formats are available, chosen by a mode input. In wide mode every sample the converter delivers leaves on two parallel 8-bit buses one clock later. This includes blanking and burst-reference samples. The valid strobe follows the converter's pulses exactly, and a separate flag marks visible video. In byte mode only visible samples are kept. Each pair of them becomes a four-byte group, sent on the luma bus in the order Cb, Y, Cr, Y. The group passes through a 32-entry FIFO, which drains one byte per clock toward the port. The visible-video flag is held high for as long as byte mode is selected.

Top module: `ycc_port_fmt`

## Requirements
- R1: While rstN is low, outValid, outActive, ovfErr, outLuma and outChroma are all 0, the FIFO is empty and the mode register is set to wide mode.
- R2: In wide mode (modeByte = 0), outValid, outLuma and outChroma equal inValid, inLuma and inChroma from the previous clock. Samples with inActive low are also passed on.
- R3: In wide mode, outActive equals inActive from the previous clock.
- R4: From the clock after modeByte is sampled high, outActive stays 1 for as long as byte mode is held.
- R5: In byte mode, two consecutive accepted samples (inValid and inActive both high) form one group. The first sample carries Cb and Y0, the second carries Cr and Y1. The group leaves on outLuma as byte 0 = Cb, byte 1 = Y0, byte 2 = Cr, byte 3 = Y1.
- R6: In byte mode, samples with inActive low are dropped. Any clock with inActive low also discards a half-formed group, so the next accepted sample is taken as Cb.
- R7: A group is written to the FIFO in one clock, and only if at least four entries are free as counted before that clock's read. Its four bytes then leave on four consecutive clocks.
- R8: A group that does not fit is dropped whole. ovfErr then goes to 1 and stays 1 until reset.
- R9: When modeByte differs from its value on the previous clock, the FIFO is emptied, the half-formed group is discarded, and the sample presented in that clock is dropped. outValid is 0 in the following clock.
- R10: In byte mode, one byte leaves per clock whenever the FIFO holds data, and outChroma is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rstN | input | 1 | Asynchronous active-low reset |
| modeByte | input | 1 | 0 = wide two-bus mode, 1 = byte mode through the FIFO |
| inValid | input | 1 | Converter has a sample this clock |
| inActive | input | 1 | Sample lies in visible video |
| inLuma | input | 8 | Luma of the sample |
| inChroma | input | 8 | Chroma of the sample (Cb on the first of a pair, Cr on the second) |
| outLuma | output | 8 | Luma in wide mode; the byte stream in byte mode |
| outChroma | output | 8 | Chroma in wide mode; 0 in byte mode |
| outValid | output | 1 | Data on the port is valid this clock |
| outActive | output | 1 | Visible video in wide mode; held high in byte mode |
| ovfErr | output | 1 | Sticky flag: a group was dropped for lack of FIFO space |

## Verification
The bench feeds a lone first-of-pair sample and then blanking samples. A design that keeps the half-formed group, or passes blanking samples into the FIFO, shifts every later byte out of Cb, Y, Cr, Y order. Pairs arriving with gaps between them test that the four bytes of a group still leave back to back. A design that writes bytes one at a time, or that reads one byte of a group before the rest is stored, leaves holes in a group. Back-to-back pairs overfill the FIFO. The bench expects only whole, in-order groups and a raised error flag; a design with wrapping pointers returns stale or torn groups instead. Finally, the mode is switched while the FIFO holds data and while a group is half formed. Stale bytes after the switch, or a group built from a pre-switch sample, reveal a missing flush.

// File: rtl/ycc_fmt_pkg.sv
package ycc_fmt_pkg;
  // Bytes in one 4:2:2 group (Cb, Y0, Cr, Y1).
  localparam int GROUP = 4;

  typedef struct packed {
    logic flush;      // mode changed: empty FIFO, drop sample
    logic byteMode;   // current mode as seen this clock
    logic holdFirst;  // capture first half of a pair
    logic pushGroup;  // write a complete group into the FIFO
    logic pop;        // send one FIFO byte to the port
  } fmtStrobe_t;
endpackage

// File: rtl/ycc_fmt_ctrl.sv
module ycc_fmt_ctrl
  import ycc_fmt_pkg::*;
#(
  parameter int DEPTH = 32
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       modeByte,
  input  logic       inValid,
  input  logic       inActive,
  output fmtStrobe_t strobe,
  output logic       ovfErr
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);
  localparam logic [CW-1:0] GROUP_C = CW'(GROUP);

  logic          modeQ;
  logic          phaseCr;
  logic [CW-1:0] fill;
  logic          take;
  logic          pairDone;
  logic          room;

  always_comb begin
    strobe.flush    = modeByte != modeQ;
    strobe.byteMode = modeByte;
    take            = modeByte && !strobe.flush && inValid && inActive;
    strobe.holdFirst = take && !phaseCr;
    pairDone        = take && phaseCr;
    room            = (DEPTH_C - fill) >= GROUP_C;
    strobe.pushGroup = pairDone && room;
    strobe.pop      = modeByte && !strobe.flush && (fill != '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ   <= 1'b0;
      phaseCr <= 1'b0;
      fill    <= '0;
      ovfErr  <= 1'b0;
    end else begin
      modeQ <= modeByte;
      if (strobe.flush) begin
        fill    <= '0;
        phaseCr <= 1'b0;
      end else begin
        fill <= fill + (strobe.pushGroup ? GROUP_C : '0)
                     - {{(CW-1){1'b0}}, strobe.pop};
        if (!inActive)
          phaseCr <= 1'b0;
        else if (take)
          phaseCr <= !phaseCr;
      end
      if (pairDone && !room)
        ovfErr <= 1'b1;
    end
  end
endmodule

// File: rtl/ycc_fmt_dpath.sv
module ycc_fmt_dpath
  import ycc_fmt_pkg::*;
#(
  parameter int DEPTH = 32
) (
  input  logic       clk,
  input  logic       rstN,
  input  fmtStrobe_t strobe,
  input  logic       inValid,
  input  logic       inActive,
  input  logic [7:0] inLuma,
  input  logic [7:0] inChroma,
  output logic [7:0] outLuma,
  output logic [7:0] outChroma,
  output logic       outValid,
  output logic       outActive
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW-1:0] GROUP_P = AW'(GROUP);

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wrPtr;
  logic [AW-1:0] rdPtr;
  logic [7:0]    holdCb;
  logic [7:0]    holdY0;
  logic [7:0]    grp [GROUP];

  always_comb begin
    grp[0] = holdCb;
    grp[1] = holdY0;
    grp[2] = inChroma;
    grp[3] = inLuma;
  end

  always_ff @(posedge clk) begin
    if (strobe.pushGroup && !strobe.flush)
      for (int k = 0; k < GROUP; k++)
        mem[wrPtr + AW'(k)] <= grp[k];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      holdCb    <= '0;
      holdY0    <= '0;
      outLuma   <= '0;
      outChroma <= '0;
      outValid  <= 1'b0;
      outActive <= 1'b0;
    end else begin
      if (strobe.flush) begin
        wrPtr <= '0;
        rdPtr <= '0;
      end else begin
        if (strobe.pushGroup) wrPtr <= wrPtr + GROUP_P;
        if (strobe.pop)       rdPtr <= rdPtr + 1'b1;
      end
      if (strobe.holdFirst) begin
        holdCb <= inChroma;
        holdY0 <= inLuma;
      end
      outActive <= strobe.byteMode || inActive;
      if (strobe.flush)
        outValid <= 1'b0;
      else
        outValid <= strobe.byteMode ? strobe.pop : inValid;
      outLuma   <= strobe.byteMode ? mem[rdPtr] : inLuma;
      outChroma <= strobe.byteMode ? 8'h00 : inChroma;
    end
  end
endmodule

// File: rtl/ycc_port_fmt.sv
module ycc_port_fmt
  import ycc_fmt_pkg::*;
#(
  parameter int DEPTH = 32
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       modeByte,
  input  logic       inValid,
  input  logic       inActive,
  input  logic [7:0] inLuma,
  input  logic [7:0] inChroma,
  output logic [7:0] outLuma,
  output logic [7:0] outChroma,
  output logic       outValid,
  output logic       outActive,
  output logic       ovfErr
);
  fmtStrobe_t strobe;

  ycc_fmt_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .modeByte(modeByte), .inValid(inValid),
    .inActive(inActive), .strobe(strobe), .ovfErr(ovfErr)
  );

  ycc_fmt_dpath #(.DEPTH(DEPTH)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .inValid(inValid),
    .inActive(inActive), .inLuma(inLuma), .inChroma(inChroma),
    .outLuma(outLuma), .outChroma(outChroma), .outValid(outValid),
    .outActive(outActive)
  );
endmodule

// File: rtl/ycc_fmt_chk.sv
module ycc_fmt_chk (
  input logic       clk,
  input logic       rstN,
  input logic       modeByte,
  input logic       inValid,
  input logic       inActive,
  input logic [7:0] inLuma,
  input logic [7:0] inChroma,
  input logic [7:0] outLuma,
  input logic [7:0] outChroma,
  input logic       outValid,
  input logic       outActive,
  input logic       ovfErr
);
  logic       prevMode;
  logic [1:0] byteIdx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevMode <= 1'b0;
      byteIdx  <= '0;
    end else begin
      prevMode <= modeByte;
      if (modeByte != prevMode)
        byteIdx <= '0;
      else if (outValid && modeByte)
        byteIdx <= byteIdx + 1'b1;
    end
  end

  assert_wide_pass_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!modeByte && !prevMode) |=> (outValid == $past(inValid) &&
      outLuma == $past(inLuma) && outChroma == $past(inChroma)));

  assert_active_wide_R3: assert property (@(posedge clk) disable iff (!rstN)
    !modeByte |=> (outActive == $past(inActive)));

  assert_active_byte_R4: assert property (@(posedge clk) disable iff (!rstN)
    modeByte |=> outActive);

  assert_no_split_R7: assert property (@(posedge clk) disable iff (!rstN)
    (modeByte && modeByte == prevMode && outValid && byteIdx != 2'd3) |=> outValid);

  assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    ovfErr |=> ovfErr);

  assert_flush_R9: assert property (@(posedge clk) disable iff (!rstN)
    (modeByte != prevMode) |=> !outValid);

  assert_chroma_zero_R10: assert property (@(posedge clk) disable iff (!rstN)
    modeByte |=> (outChroma == 8'h00));
endmodule

bind ycc_port_fmt ycc_fmt_chk u_chk (
  .clk(clk), .rstN(rstN), .modeByte(modeByte), .inValid(inValid),
  .inActive(inActive), .inLuma(inLuma), .inChroma(inChroma),
  .outLuma(outLuma), .outChroma(outChroma), .outValid(outValid),
  .outActive(outActive), .ovfErr(ovfErr)
);

// File: tb/sim_ycc_port_fmt.sv
`timescale 1ns/1ps
module sim_ycc_port_fmt;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       modeByte = 1'b0;
  logic       inValid = 1'b0;
  logic       inActive = 1'b0;
  logic [7:0] inLuma = '0;
  logic [7:0] inChroma = '0;
  logic [7:0] outLuma;
  logic [7:0] outChroma;
  logic       outValid;
  logic       outActive;
  logic       ovfErr;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit collect = 1'b0;
  bit finished = 1'b0;
  int rxQ[$];
  int rxCyc[$];

  always #5 clk = ~clk;

  ycc_port_fmt u0 (
    .clk(clk), .rstN(rstN), .modeByte(modeByte), .inValid(inValid),
    .inActive(inActive), .inLuma(inLuma), .inChroma(inChroma),
    .outLuma(outLuma), .outChroma(outChroma), .outValid(outValid),
    .outActive(outActive), .ovfErr(ovfErr)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (collect && outValid) begin
      rxQ.push_back(int'(outLuma));
      rxCyc.push_back(cyc);
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic sendSample(input bit v, input bit a, input int y, input int c);
    @(negedge clk);
    inValid  = v;
    inActive = a;
    inLuma   = 8'(y);
    inChroma = 8'(c);
  endtask

  task automatic sendPair(input int base);
    sendSample(1'b1, 1'b1, base + 1, base);
    sendSample(1'b1, 1'b1, base + 3, base + 2);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) sendSample(1'b0, 1'b1, 0, 0);
  endtask

  task automatic setMode(input bit m);
    @(negedge clk);
    modeByte = m;
    inValid  = 1'b0;
  endtask

  task automatic clearRx();
    rxQ.delete();
    rxCyc.delete();
  endtask

  // Checks byte values start..start+n-1 and that groups leave on adjacent clocks.
  task automatic checkStream(input int start, input int n, input string req);
    chk(rxQ.size() == n, req, rxQ.size(), n);
    for (int i = 0; i < rxQ.size() && i < n; i++)
      chk(rxQ[i] == start + i, req, rxQ[i], start + i);
    for (int i = 0; i < rxQ.size(); i++)
      if (i % 4 != 0)
        chk(rxCyc[i] == rxCyc[i-1] + 1, "R7", rxCyc[i] - rxCyc[i-1], 1);
  endtask

  task automatic testReset();
    @(negedge clk);
    rstN = 1'b0; modeByte = 1'b0; inValid = 1'b0; inActive = 1'b0;
    repeat (3) @(negedge clk);
    chk(outValid == 0 && outActive == 0, "R1", {outValid, outActive}, 0);
    chk(ovfErr == 0, "R1", ovfErr, 0);
    chk(outLuma == 0 && outChroma == 0, "R1", {outLuma, outChroma}, 0);
    rstN = 1'b1;
  endtask

  task automatic testWide();
    bit pv = 0, pa = 0;
    int py = 0, pc = 0;
    for (int i = 0; i <= 10; i++) begin
      @(negedge clk);
      if (i > 0) begin
        chk(outValid == pv, "R2", outValid, pv);
        if (pv) begin
          chk(outLuma == 8'(py), "R2", outLuma, py);
          chk(outChroma == 8'(pc), "R2", outChroma, pc);
        end
        chk(outActive == pa, "R3", outActive, pa);
      end
      if (i < 10) begin
        pv = (i % 3 != 2);
        pa = (i >= 3 && i < 8);
        py = (i * 7 + 1) & 255;
        pc = (i * 5 + 2) & 255;
        inValid = pv; inActive = pa; inLuma = 8'(py); inChroma = 8'(pc);
      end
    end
  endtask

  task automatic testByteOrder();
    setMode(1'b1);
    @(negedge clk);
    chk(outActive == 1, "R4", outActive, 1);
    clearRx();
    collect = 1'b1;
    sendPair(0); sendPair(4); sendPair(8);
    idle(20);
    checkStream(0, 12, "R5");
    chk(outChroma == 0, "R10", outChroma, 0);
    chk(outActive == 1, "R4", outActive, 1);
    collect = 1'b0;
  endtask

  task automatic testBlanking();
    clearRx();
    collect = 1'b1;
    sendSample(1'b1, 1'b1, 8'hE1, 8'hE0);
    sendSample(1'b1, 1'b0, 8'hE3, 8'hE2);
    sendSample(1'b1, 1'b0, 8'hE5, 8'hE4);
    sendPair(40); sendPair(44);
    idle(15);
    checkStream(40, 8, "R6");
    collect = 1'b0;
  endtask

  task automatic testGaps();
    clearRx();
    collect = 1'b1;
    sendSample(1'b1, 1'b1, 61, 60);
    idle(2);
    sendSample(1'b1, 1'b1, 63, 62);
    idle(1);
    sendPair(64);
    idle(3);
    sendSample(1'b1, 1'b1, 69, 68);
    sendSample(1'b0, 1'b1, 0, 0);
    sendSample(1'b1, 1'b1, 71, 70);
    idle(15);
    checkStream(60, 12, "R7");
    collect = 1'b0;
  endtask

  task automatic testOverflow();
    int groups;
    chk(ovfErr == 0, "R8", ovfErr, 0);
    clearRx();
    collect = 1'b1;
    for (int g = 0; g < 40; g++) sendPair(g * 4);
    idle(80);
    collect = 1'b0;
    chk(ovfErr == 1, "R8", ovfErr, 1);
    groups = rxQ.size() / 4;
    chk(rxQ.size() % 4 == 0, "R8", rxQ.size() % 4, 0);
    chk(groups >= 8 && groups < 40, "R8", groups, 20);
    if (rxQ.size() > 0) chk(rxQ[0] == 0, "R8", rxQ[0], 0);
    for (int i = 0; i < rxQ.size(); i++) begin
      if (i % 4 == 0) begin
        chk(rxQ[i] % 4 == 0, "R8", rxQ[i] % 4, 0);
        if (i > 0) chk(rxQ[i] > rxQ[i-4], "R8", rxQ[i], rxQ[i-4] + 4);
      end else begin
        chk(rxQ[i] == rxQ[i-1] + 1, "R7", rxQ[i], rxQ[i-1] + 1);
        chk(rxCyc[i] == rxCyc[i-1] + 1, "R7", rxCyc[i] - rxCyc[i-1], 1);
      end
    end
    idle(3);
    chk(ovfErr == 1, "R8", ovfErr, 1);
  endtask

  task automatic testModeSwitch();
    setMode(1'b1);
    idle(3);
    for (int g = 0; g < 6; g++) sendPair(100 + g * 4);
    setMode(1'b0);
    @(negedge clk);
    chk(outValid == 0, "R9", outValid, 0);
    for (int i = 0; i < 4; i++) begin
      sendSample(1'b0, 1'b0, 0, 0);
      chk(outValid == 0, "R9", outValid, 0);
    end
    clearRx();
    setMode(1'b1);
    collect = 1'b1;
    idle(10);
    chk(rxQ.size() == 0, "R9", rxQ.size(), 0);
    sendSample(1'b1, 1'b1, 8'hAB, 8'hAA);
    setMode(1'b0);
    setMode(1'b1);
    sendPair(200);
    idle(12);
    checkStream(200, 4, "R9");
    collect = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    testReset();
    testWide();
    testByteOrder();
    testBlanking();
    testGaps();
    testOverflow();
    testReset();
    testModeSwitch();
    testReset();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule